// File: doc/BRIEF.md
# Microstep Phase Sequencer with Idle Detect

This block walks a two-phase bipolar motor through its electrical cycle. It moves one table entry for each rising edge seen on a step input. A position counter holds the current entry. From that entry the block derives a signed current setpoint for each coil: a magnitude in percent of full scale and a polarity bit. The magnitudes follow a quarter-wave cosine table, and the polarities come from the quadrant the position lies in, so the two coils trace a full cosine/sine pair.

There are eight resolutions. Six of them are binary, from 2 to 128 entries per quarter cycle. Two are decimal, with 10 and 20 entries per quarter cycle.

A direction input sets which way the position moves. A home-reset input parks the position at its starting point. An enable input blanks the coil setpoints but lets the counter keep moving. A standby input clears the block. Two flags are also produced. The first marks the starting position. The second rises once step edges have stopped for a programmable time, so that the surrounding system can lower the holding current.

Top module: `mstep_seq`

## Requirements
- R1: After reset, or after `home_rst_n` has been low, the position is the initial one: coil A +100, coil B 0 with both polarity bits 0, and `home_n` = 0.
- R2: `step_in` passes through a two-flop synchroniser. The position moves by exactly one entry for each detected rising edge. Let E be the first clock edge that samples `step_in` high. The coil outputs change on edge E+3. A level held high moves the position only once.
- R3: `res_sel` picks N, the number of entries per quarter cycle: 0→2, 1→8, 2→16, 3→32, 4→64, 5→128, 6→10, 7→20. At quarter index k, the near magnitude is round(100·cos(k·90°/N)). Examples: with code 6, k=1 gives 99/16; with code 0, k=1 gives 71/71.
- R4: With `dir_ccw` = 0, the position increments, so coil B lags coil A by 90°. With `dir_ccw` = 1, it decrements from wherever it is.
- R5: While `home_rst_n` is low, the position is held at the initial one, and step edges and `dir_ccw` have no effect.
- R6: While `standby_n` is low, both magnitudes are 0, `idle` is 0 and the position returns to the initial one.
- R7: While `out_en` is low, both magnitudes and polarity bits are 0, but step edges still move the position. Once `out_en` returns high, the outputs show the moved position one clock later.
- R8: `home_n` is 0 exactly when the position one clock earlier was the initial one. It is 1 otherwise.
- R9: Let L be the value of `idle_limit`, and let no further step edge arrive. Then `idle` rises on the (L+1)-th clock edge after the edge that detected the last step, and it stays high.
- R10: `idle` returns to 0 on the clock edge after a step edge is detected.
- R11: The position index p runs over 0..4N-1 and wraps in both directions. Coil A carries the sign of cos(p·90°/N) and coil B the sign of sin(p·90°/N). A polarity bit of 1 means negative, and it is 0 whenever its magnitude is 0.
- R12: `res_sel` is sampled only while `home_rst_n` or `standby_n` is low. A change at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_n | input | 1 | Low: clear the logic and turn the outputs off |
| home_rst_n | input | 1 | Low: park the position at the initial entry |
| out_en | input | 1 | Low: blank the coil setpoints |
| step_in | input | 1 | Step input; each rising edge moves the position one entry |
| dir_ccw | input | 1 | Direction: 0 increments, 1 decrements |
| res_sel | input | 3 | Resolution code |
| idle_limit | input | IDLE_W | Idle timeout, in clock cycles |
| coil_a_mag | output | 7 | Coil A magnitude, in percent |
| coil_a_neg | output | 1 | Coil A polarity, 1 = negative |
| coil_b_mag | output | 7 | Coil B magnitude, in percent |
| coil_b_neg | output | 1 | Coil B polarity, 1 = negative |
| home_n | output | 1 | Low at the initial position |
| idle | output | 1 | High after step edges have stopped for the timeout |

## Verification
A position counter that is off by one entry, or that wraps at the wrong modulus, shows up one clock after the faulty update. At that point the coil magnitude or sign pair no longer matches the reference cosine and sine. Every later step repeats the error, because the reference keeps its own position. A wrong latched resolution shows up at the first step after a home reset, as the wrong angle increment. A faulty idle counter shows up as `idle` rising one or more clocks early or late relative to L+1, or as `idle` failing to drop on the edge after a step is detected.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

   localparam int PCT_W    = 7;
   localparam int BIN_FINE = 128;
   localparam int DEC_FINE = 20;
   localparam int IDX_W    = $clog2(BIN_FINE);
   localparam int QLEN_W   = IDX_W + 1;
   localparam int BIN_IW   = $clog2(BIN_FINE + 1);
   localparam int DEC_IW   = $clog2(DEC_FINE + 1);

   typedef enum logic [2:0] {
      RES_HALF = 3'd0,
      RES_8    = 3'd1,
      RES_16   = 3'd2,
      RES_32   = 3'd3,
      RES_64   = 3'd4,
      RES_128  = 3'd5,
      RES_10   = 3'd6,
      RES_20   = 3'd7
   } res_e;

   typedef struct packed {
      logic [1:0]       quad;
      logic [IDX_W-1:0] idx;
   } pos_t;

   typedef struct packed {
      logic             neg;
      logic [PCT_W-1:0] mag;
   } coil_t;

   function automatic logic [QLEN_W-1:0] quarter_len(res_e r);
      case (r)
         RES_HALF: return QLEN_W'(2);
         RES_8:    return QLEN_W'(8);
         RES_16:   return QLEN_W'(16);
         RES_32:   return QLEN_W'(32);
         RES_64:   return QLEN_W'(64);
         RES_128:  return QLEN_W'(128);
         RES_10:   return QLEN_W'(10);
         default:  return QLEN_W'(20);
      endcase
   endfunction

   function automatic logic [2:0] fine_shift(res_e r);
      case (r)
         RES_HALF: return 3'd6;
         RES_8:    return 3'd4;
         RES_16:   return 3'd3;
         RES_32:   return 3'd2;
         RES_64:   return 3'd1;
         RES_10:   return 3'd1;
         default:  return 3'd0;
      endcase
   endfunction

   function automatic logic is_decimal(res_e r);
      return (r == RES_10) || (r == RES_20);
   endfunction

   function automatic int cos_pct(int k, int n);
      longint x;
      longint x2;
      longint term;
      longint acc;
      longint res;
      x    = (longint'(k) * 64'sd843314857) / longint'(2 * n);
      x2   = (x * x) >>> 28;
      term = 64'sd1 <<< 28;
      acc  = term;
      for (int j = 1; j <= 9; j++) begin
         term = -((term * x2) >>> 28) / longint'((2 * j - 1) * (2 * j));
         acc  = acc + term;
      end
      res = (acc * 64'sd100 + (64'sd1 <<< 27)) >>> 28;
      if (res < 0)   res = 0;
      if (res > 100) res = 100;
      return int'(res);
   endfunction

endpackage

// File: rtl/mstep_sync_rise.sv
module mstep_sync_rise #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mstep_sync_rise: STAGES must be at least 2");
   end

   logic [STAGES:0] chain;

   for (genvar gs = 0; gs <= STAGES; gs++) begin : g_stage
      if (gs == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[gs] <= 1'b0;
            else        chain[gs] <= chain[gs-1];
         end
      end
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/mstep_pos_ctr.sv
module mstep_pos_ctr
   import mstep_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic adv,
   input  logic dir_ccw,
   input  res_e res_in,
   output pos_t pos,
   output res_e res_q
);

   logic [QLEN_W-1:0] qlen;
   logic [IDX_W-1:0]  last;

   assign qlen = quarter_len(res_q);
   assign last = IDX_W'(qlen - QLEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos   <= '0;
         res_q <= RES_HALF;
      end else if (hold) begin
         pos   <= '0;
         res_q <= res_in;
      end else if (adv) begin
         if (!dir_ccw) begin
            if (pos.idx == last) begin
               pos.idx  <= '0;
               pos.quad <= pos.quad + 2'd1;
            end else begin
               pos.idx  <= pos.idx + IDX_W'(1);
            end
         end else begin
            if (pos.idx == '0) begin
               pos.idx  <= last;
               pos.quad <= pos.quad - 2'd1;
            end else begin
               pos.idx  <= pos.idx - IDX_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/mstep_wave_lut.sv
module mstep_wave_lut
   import mstep_pkg::*;
(
   input  pos_t  pos,
   input  res_e  res,
   output coil_t coil_a,
   output coil_t coil_b
);

   logic [PCT_W-1:0] bin_rom [BIN_FINE+1];
   logic [PCT_W-1:0] dec_rom [DEC_FINE+1];

   for (genvar gb = 0; gb <= BIN_FINE; gb++) begin : g_bin
      assign bin_rom[gb] = PCT_W'(cos_pct(gb, BIN_FINE));
   end

   for (genvar gd = 0; gd <= DEC_FINE; gd++) begin : g_dec
      assign dec_rom[gd] = PCT_W'(cos_pct(gd, DEC_FINE));
   end

   logic [QLEN_W-1:0] qlen;
   logic [QLEN_W-1:0] k_near;
   logic [QLEN_W-1:0] k_far;
   logic [QLEN_W-1:0] fine_near;
   logic [QLEN_W-1:0] fine_far;
   logic [PCT_W-1:0]  v_near;
   logic [PCT_W-1:0]  v_far;
   coil_t             raw_a;
   coil_t             raw_b;

   always_comb begin
      qlen      = quarter_len(res);
      k_near    = {1'b0, pos.idx};
      k_far     = qlen - k_near;
      fine_near = k_near << fine_shift(res);
      fine_far  = k_far  << fine_shift(res);
      if (is_decimal(res)) begin
         v_near = dec_rom[DEC_IW'(fine_near)];
         v_far  = dec_rom[DEC_IW'(fine_far)];
      end else begin
         v_near = bin_rom[BIN_IW'(fine_near)];
         v_far  = bin_rom[BIN_IW'(fine_far)];
      end
   end

   always_comb begin
      case (pos.quad)
         2'd0: begin raw_a = '{neg: 1'b0, mag: v_near}; raw_b = '{neg: 1'b0, mag: v_far};  end
         2'd1: begin raw_a = '{neg: 1'b1, mag: v_far};  raw_b = '{neg: 1'b0, mag: v_near}; end
         2'd2: begin raw_a = '{neg: 1'b1, mag: v_near}; raw_b = '{neg: 1'b1, mag: v_far};  end
         default: begin raw_a = '{neg: 1'b0, mag: v_far}; raw_b = '{neg: 1'b1, mag: v_near}; end
      endcase
      coil_a     = raw_a;
      coil_b     = raw_b;
      coil_a.neg = raw_a.neg & (raw_a.mag != '0);
      coil_b.neg = raw_b.neg & (raw_b.mag != '0);
   end

endmodule

// File: rtl/mstep_idle_timer.sv
module mstep_idle_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         hit,
   input  logic [W-1:0] limit,
   output logic         idle
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         idle <= 1'b0;
      end else if (clr || hit) begin
         cnt  <= '0;
         idle <= 1'b0;
      end else if (cnt >= limit) begin
         idle <= 1'b1;
      end else begin
         cnt  <= cnt + W'(1);
      end
   end

endmodule

// File: rtl/mstep_seq.sv
module mstep_seq
   import mstep_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby_n,
   input  logic              home_rst_n,
   input  logic              out_en,
   input  logic              step_in,
   input  logic              dir_ccw,
   input  logic [2:0]        res_sel,
   input  logic [IDLE_W-1:0] idle_limit,
   output logic [PCT_W-1:0]  coil_a_mag,
   output logic              coil_a_neg,
   output logic [PCT_W-1:0]  coil_b_mag,
   output logic              coil_b_neg,
   output logic              home_n,
   output logic              idle
);

   if (IDLE_W < 1) begin : g_bad_idle
      $error("mstep_seq: IDLE_W must be at least 1");
   end

   logic  step_rise;
   logic  hold;
   pos_t  pos_q;
   res_e  res_q;
   coil_t lut_a;
   coil_t lut_b;

   assign hold = ~standby_n | ~home_rst_n;

   mstep_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (step_in),
      .rise (step_rise)
   );

   mstep_pos_ctr u_pos (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (hold),
      .adv    (step_rise),
      .dir_ccw(dir_ccw),
      .res_in (res_e'(res_sel)),
      .pos    (pos_q),
      .res_q  (res_q)
   );

   mstep_wave_lut u_lut (
      .pos   (pos_q),
      .res   (res_q),
      .coil_a(lut_a),
      .coil_b(lut_b)
   );

   mstep_idle_timer #(.W(IDLE_W)) u_idle (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (~standby_n),
      .hit  (step_rise),
      .limit(idle_limit),
      .idle (idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coil_a_mag <= '0;
         coil_a_neg <= 1'b0;
         coil_b_mag <= '0;
         coil_b_neg <= 1'b0;
         home_n     <= 1'b0;
      end else begin
         if (!standby_n || !out_en) begin
            coil_a_mag <= '0;
            coil_a_neg <= 1'b0;
            coil_b_mag <= '0;
            coil_b_neg <= 1'b0;
         end else begin
            coil_a_mag <= lut_a.mag;
            coil_a_neg <= lut_a.neg;
            coil_b_mag <= lut_b.mag;
            coil_b_neg <= lut_b.neg;
         end
         home_n <= (pos_q != '0);
      end
   end

endmodule

// File: rtl/mstep_seq_chk.sv
module mstep_seq_chk
   import mstep_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             standby_n,
   input logic             home_rst_n,
   input logic             out_en,
   input logic             step_rise,
   input pos_t             pos_q,
   input res_e             res_q,
   input logic [PCT_W-1:0] coil_a_mag,
   input logic [PCT_W-1:0] coil_b_mag,
   input logic             home_n,
   input logic             idle
);

   // R2: with no detected edge and no hold, the position does not move
   assert_pos_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_rise && standby_n && home_rst_n) |=> $stable(pos_q));

   // R5: home reset parks the position
   assert_home_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!home_rst_n) |=> (pos_q == '0));

   // R6: standby blanks the coils and clears idle
   assert_standby_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby_n) |=> (coil_a_mag == '0 && coil_b_mag == '0 && !idle));

   // R7: disabled outputs carry zero magnitude
   assert_oe_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en) |=> (coil_a_mag == '0 && coil_b_mag == '0));

   // R8: home flag follows the position one clock later
   assert_home_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      standby_n |=> (home_n == ($past(pos_q) != '0)));

   // R10: a detected edge clears idle
   assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      step_rise |=> !idle);

   // R12: resolution held outside of reset
   assert_res_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (standby_n && home_rst_n) |=> $stable(res_q));

endmodule

bind mstep_seq mstep_seq_chk u_chk (.*);

// File: tb/sim_mstep_seq.sv
`timescale 1ns/1ps
module sim_mstep_seq;

   localparam int IW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          standby_n = 1'b1;
   logic          home_rst_n = 1'b0;
   logic          out_en = 1'b1;
   logic          step_in = 1'b0;
   logic          dir_ccw = 1'b0;
   logic [2:0]    res_sel = 3'd6;
   logic [IW-1:0] idle_limit = 16'd40;
   logic [6:0]    coil_a_mag;
   logic          coil_a_neg;
   logic [6:0]    coil_b_mag;
   logic          coil_b_neg;
   logic          home_n;
   logic          idle;

   always #4 clk = ~clk;

   mstep_seq #(.SYNC_STAGES(2), .IDLE_W(IW)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .standby_n (standby_n),
      .home_rst_n(home_rst_n),
      .out_en    (out_en),
      .step_in   (step_in),
      .dir_ccw   (dir_ccw),
      .res_sel   (res_sel),
      .idle_limit(idle_limit),
      .coil_a_mag(coil_a_mag),
      .coil_a_neg(coil_a_neg),
      .coil_b_mag(coil_b_mag),
      .coil_b_neg(coil_b_neg),
      .home_n    (home_n),
      .idle      (idle)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   int    cyc = 0;
   bit    chk_on = 0;
   bit    done = 0;
   string cur_req = "R1";

   // reference model state
   int m_pos = 0;
   int m_n   = 2;
   int m_cnt = 0;
   bit m_s1 = 0, m_s2 = 0, m_s3 = 0;
   bit m_rise;
   int e_am = 0, e_bm = 0;
   bit e_an = 0, e_bn = 0, e_home = 0, e_idle = 0;

   function automatic int qlen_of(int code);
      case (code)
         0: return 2;
         1: return 8;
         2: return 16;
         3: return 32;
         4: return 64;
         5: return 128;
         6: return 10;
         default: return 20;
      endcase
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_pos = 0; m_n = 2; m_cnt = 0;
         m_s1 = 0; m_s2 = 0; m_s3 = 0;
         e_am = 0; e_bm = 0; e_an = 0; e_bn = 0; e_home = 0; e_idle = 0;
      end else begin
         real ang, ra, rb;
         m_rise = m_s2 && !m_s3;
         if (!standby_n || !out_en) begin
            e_am = 0; e_bm = 0; e_an = 0; e_bn = 0;
         end else begin
            ang  = (real'(m_pos) * 90.0 / real'(m_n)) * 3.14159265358979 / 180.0;
            ra   = 100.0 * $cos(ang);
            rb   = 100.0 * $sin(ang);
            e_am = int'(ra < 0.0 ? -ra : ra);
            e_bm = int'(rb < 0.0 ? -rb : rb);
            e_an = (ra < 0.0) && (e_am != 0);
            e_bn = (rb < 0.0) && (e_bm != 0);
         end
         e_home = (m_pos != 0);
         if (!standby_n || m_rise) begin
            m_cnt = 0; e_idle = 0;
         end else if (m_cnt >= int'(idle_limit)) begin
            e_idle = 1;
         end else begin
            m_cnt++;
         end
         if (!standby_n || !home_rst_n) begin
            m_pos = 0;
            m_n   = qlen_of(int'(res_sel));
         end else if (m_rise) begin
            if (dir_ccw) m_pos = (m_pos + 4 * m_n - 1) % (4 * m_n);
            else         m_pos = (m_pos + 1) % (4 * m_n);
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = step_in;
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (chk_on && !done) begin
         int act, exp;
         act = {coil_a_neg, coil_a_mag, coil_b_neg, coil_b_mag, home_n, idle};
         exp = {e_an, 7'(e_am), e_bn, 7'(e_bm), e_home, e_idle};
         n_chk++;
         if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d actual=%0h expected=%0h", cur_req, cyc, act, exp);
         end
      end
   end

   task automatic lit(string tag, int am, bit an, int bm, bit bn, bit hm);
      n_chk++;
      if (coil_a_mag !== 7'(am) || coil_a_neg !== an || coil_b_mag !== 7'(bm) ||
          coil_b_neg !== bn || home_n !== hm) begin
         n_fail++;
         $display("FAIL %s actual=%0d/%0d,%0d/%0d,%0d expected=%0d/%0d,%0d/%0d,%0d", tag,
                  coil_a_neg, coil_a_mag, coil_b_neg, coil_b_mag, home_n, an, am, bn, bm, hm);
      end
   endtask

   task automatic flag(string tag, bit act, bit exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pulse();
      step_in = 1'b1;
      repeat (3) @(negedge clk);
      step_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      chk_on = 1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      home_rst_n = 1'b1;
      repeat (2) @(negedge clk);
      lit("R1 initial", 100, 0, 0, 0, 0);

      cur_req = "R3";
      pulse();
      lit("R3 decimal k=1", 99, 0, 16, 0, 1);

      cur_req = "R2";
      repeat (11) pulse();
      lit("R11 quadrant1", 31, 1, 95, 0, 1);
      step_in = 1'b1;
      repeat (20) @(negedge clk);
      step_in = 1'b0;
      repeat (3) @(negedge clk);
      lit("R2 held level one step", 45, 1, 89, 0, 1);

      cur_req = "R4";
      dir_ccw = 1'b1;
      repeat (3) pulse();
      lit("R4 reverse", 0, 0, 100, 0, 1);

      cur_req = "R7";
      out_en = 1'b0;
      repeat (2) pulse();
      lit("R7 blanked", 0, 0, 0, 0, 1);
      out_en = 1'b1;
      @(negedge clk);
      lit("R7 restored", 31, 0, 95, 0, 1);

      cur_req = "R5";
      home_rst_n = 1'b0;
      res_sel = 3'd0;
      pulse();
      dir_ccw = 1'b0;
      pulse();
      lit("R5 parked", 100, 0, 0, 0, 0);
      home_rst_n = 1'b1;

      cur_req = "R12";
      repeat (2) @(negedge clk);
      res_sel = 3'd5;
      pulse();
      lit("R12 mode kept", 71, 0, 71, 0, 1);

      cur_req = "R8";
      repeat (7) pulse();
      lit("R8 wrap home", 100, 0, 0, 0, 0);

      cur_req = "R3";
      for (int m = 0; m < 8; m++) begin
         res_sel = 3'(m);
         dir_ccw = 1'b0;
         home_rst_n = 1'b0;
         repeat (2) @(negedge clk);
         home_rst_n = 1'b1;
         for (int s = 0; s < 4 * qlen_of(m) + 1; s++) pulse();
         dir_ccw = 1'b1;
         repeat (2) pulse();
      end
      dir_ccw = 1'b0;

      cur_req = "R9";
      idle_limit = 16'd20;
      repeat (40) @(negedge clk);
      flag("R9 idle after timeout", idle, 1'b1);

      cur_req = "R10";
      pulse();
      flag("R10 idle cleared", idle, 1'b0);

      cur_req = "R6";
      standby_n = 1'b0;
      repeat (3) @(negedge clk);
      lit("R6 standby", 0, 0, 0, 0, 0);
      flag("R6 standby idle", idle, 1'b0);
      standby_n = 1'b1;
      repeat (2) @(negedge clk);
      lit("R6 wake", 100, 0, 0, 0, 0);

      repeat (4) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule